// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and a calendar date as packed BCD bytes: seconds, minutes, hours (24-hour), day of month, month, two-digit year, and a weekday index. It advances by one second on each cycle in which the one-second `tick` input is high and the run bit is set. Carries ripple through the fields. Day-of-month rollover follows the length of each month, with a leap February in years divisible by four.

Software reaches the block through a byte-wide register port. A snapshot bit in the control register copies all the live counters into static shadow bytes, and reads of the time addresses always return those shadow bytes. A multi-byte read of the time therefore stays coherent while the clock keeps running. A set of six alarm bytes is compared with the freshly advanced time on every counting tick. A status register collects sticky event flags, which are cleared by writing 1. A single level interrupt output combines the alarm flag with one selectable periodic flag.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the time reads 00:00:00, day 01, month 01, year 00, weekday 00; control reads 0x00, interrupt-enable reads 0x00, status reads 0x80 and `irq` is low.
- R2: Addresses: 0x00 seconds, 0x01 minutes, 0x02 hours, 0x03 day, 0x04 month, 0x05 year, 0x06 weekday, 0x07..0x0C alarm seconds..year in the same field order, 0x0D control, 0x0E status, 0x0F interrupt enable; every other address reads 0x00.
- R3: Control bit 0 is the run bit. While it is 0, ticks leave the time unchanged and set no flags. Status bit 1 reads the run bit.
- R4: Each counting tick adds one second in BCD. Seconds carry 59→00 into minutes, minutes carry 59→00 into hours, and hours carry 23→00 into the day.
- R5: The day wraps to 01 after 28 (February, year not divisible by 4), 29 (February, leap year), 30 (April, June, September, November) or 31 (other months). The month wraps 12→01 with a year increment, and the year wraps 99→00.
- R6: The weekday counts 0..6 and advances, wrapping 6→0, on the tick that carries hours into the day.
- R7: Writing control with bit 6 set copies all seven live time bytes into the shadow bytes in that cycle. Reads of 0x00..0x06 return the shadow bytes. Control bit 6 always reads 0.
- R8: A write to a time address loads the live counter directly, whether running or not. The new value appears at the read port after the next snapshot.
- R9: On each counting tick, status bit 2 sets. Bit 3 sets when seconds carry, bit 4 when minutes carry, and bit 5 when hours carry. Each flag stays set until a status write with a 1 in its position; a 0 in a position leaves that flag unchanged.
- R10: When all six advanced fields equal the six alarm bytes on a counting tick, status bit 6 sets whether or not the alarm interrupt is enabled. It is sticky and cleared by writing 1.
- R11: Status bit 7 is set by reset and clears only on a status write with bit 7 set.
- R12: Interrupt-enable bits [1:0] select the periodic flag (0 second, 1 minute, 2 hour, 3 day), bit 2 enables it and bit 3 enables the alarm. `irq` = (status bit 6 AND bit 3) OR (selected flag AND bit 2).
- R13: `rdata` presents the addressed byte in the cycle after `rd` is sampled high and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second pulse, one clock wide |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered |
| irq | output | 1 | Level interrupt |

## Verification
A wrong carry or month-length decision appears only at a rollover. It becomes visible at the port after the next snapshot and read, so the stimulus preloads times one or two seconds short of each boundary and reads back right after the crossing. Flag and interrupt faults show at `irq` in the same cycle that the status register changes, and in the status byte on the next read. A faulty shadow path shows when a read after extra ticks returns a moved value instead of the value held since the last snapshot.

// File: rtl/bcd_rtc.sv
module bcd_rtc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  input  logic       wr,
  input  logic       rd,
  output logic [7:0] rdata,
  output logic       irq
);
  localparam logic [4:0] A_ALM  = 5'd7;
  localparam logic [4:0] A_CTRL = 5'd13;
  localparam logic [4:0] A_STAT = 5'd14;
  localparam logic [4:0] A_IEN  = 5'd15;

  logic [6:0][7:0] tm, sh, nx;
  logic [5:0][7:0] al;
  logic [5:0]      st, st_set, st_nx;
  logic [3:0]      ien;
  logic            run;
  logic [7:0]      rmux, dim;
  logic            leap, c0, c1, c2, c3, c4, amatch, step;

  function automatic logic [7:0] inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  assign step = run & tick;
  assign leap = tm[5][4] ? (tm[5][3:0] == 4'd2 || tm[5][3:0] == 4'd6)
                         : (tm[5][3:0] == 4'd0 || tm[5][3:0] == 4'd4 || tm[5][3:0] == 4'd8);

  always_comb begin
    case (tm[4])
      8'h02:                      dim = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: dim = 8'h30;
      default:                    dim = 8'h31;
    endcase
  end

  assign c0 = tm[0] == 8'h59;
  assign c1 = c0 && tm[1] == 8'h59;
  assign c2 = c1 && tm[2] == 8'h23;
  assign c3 = c2 && tm[3] == dim;
  assign c4 = c3 && tm[4] == 8'h12;

  always_comb begin
    nx[0] = c0 ? 8'h00 : inc(tm[0]);
    nx[1] = c0 ? ((tm[1] == 8'h59) ? 8'h00 : inc(tm[1])) : tm[1];
    nx[2] = c1 ? ((tm[2] == 8'h23) ? 8'h00 : inc(tm[2])) : tm[2];
    nx[3] = c2 ? ((tm[3] == dim) ? 8'h01 : inc(tm[3])) : tm[3];
    nx[4] = c3 ? ((tm[4] == 8'h12) ? 8'h01 : inc(tm[4])) : tm[4];
    nx[5] = c4 ? ((tm[5] == 8'h99) ? 8'h00 : inc(tm[5])) : tm[5];
    nx[6] = c2 ? ((tm[6] == 8'h06) ? 8'h00 : tm[6] + 8'h01) : tm[6];
  end

  assign amatch = (nx[5:0] == al);
  assign st_set = step ? {1'b0, amatch, c2, c1, c0, 1'b1} : 6'b0;
  assign st_nx  = ((wr && addr == A_STAT) ? (st & ~wdata[7:2]) : st) | st_set;

  always_comb begin
    rmux = 8'h00;
    for (int i = 0; i < 7; i++)
      if (addr == 5'(i)) rmux = sh[i];
    for (int i = 0; i < 6; i++)
      if (addr == A_ALM + 5'(i)) rmux = al[i];
    if (addr == A_CTRL) rmux = {7'd0, run};
    if (addr == A_STAT) rmux = {st, run, 1'b0};
    if (addr == A_IEN)  rmux = {4'd0, ien};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tm    <= {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      sh    <= {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};
      al    <= '0;
      st    <= 6'b100000;
      ien   <= '0;
      run   <= 1'b0;
      rdata <= '0;
    end else begin
      for (int i = 0; i < 7; i++) begin
        if (wr && addr == 5'(i)) tm[i] <= wdata;
        else if (step)           tm[i] <= nx[i];
      end
      for (int i = 0; i < 6; i++)
        if (wr && addr == A_ALM + 5'(i)) al[i] <= wdata;
      if (wr && addr == A_CTRL) begin
        run <= wdata[0];
        if (wdata[6]) sh <= tm;
      end
      if (wr && addr == A_IEN) ien <= wdata[3:0];
      st <= st_nx;
      if (rd) rdata <= rmux;
    end
  end

  assign irq = (st[4] & ien[3]) | (ien[2] & st[ien[1:0]]);

  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(tm));
  a_r4_second_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr && tm[0] != 8'h59) |=> (tm[0] != $past(tm[0])));
  a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_CTRL && wdata[6]) |=> (sh == $past(tm)));
  a_r10_alarm_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st[4] && !(wr && addr == A_STAT && wdata[6])) |=> st[4]);
  a_r11_powerup_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st[5]) |-> $past(wr && addr == A_STAT && wdata[7]));
  a_r12_alarm_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (st[4] && ien[3]) |-> irq);
endmodule

// File: tb/bcd_rtc_bench.sv
`timescale 1ns/1ps
module bcd_rtc_bench;
  logic       clk = 0, rst_n = 0, tick = 0, wr = 0, rd = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0;
  wire  [7:0] rdata;
  wire        irq;
  int         n_cmp = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_pend = 0;

  bcd_rtc u_bcd_rtc (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr),
    .wdata(wdata), .wr(wr), .rd(rd), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;
  always @(posedge clk) rd_pend <= rd;

  always @(negedge clk) begin
    if (rd_pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_cmp++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: read got %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic rdx(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk); addr = a; rd = 1; exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 0;
  endtask

  task automatic wrr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_cmp++;
    if (irq !== e) begin
      n_bad++;
      $display("FAIL %s: irq got %b expected %b", t, irq, e);
    end
  endtask

  task automatic set_clock(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wrr(0, s); wrr(1, m); wrr(2, h); wrr(3, d); wrr(4, mo); wrr(5, y);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 / R13 reset state through registered reads
    rdx(14, 8'h80, "R1 R13 status");
    rdx(15, 8'h00, "R1 ien");
    rdx(13, 8'h00, "R1 ctrl");
    chk_irq(0, "R1 irq");
    wrr(13, 8'h40);
    rdx(0, 8'h00, "R1 sec"); rdx(3, 8'h01, "R1 day"); rdx(4, 8'h01, "R1 month");
    rdx(5, 8'h00, "R1 year"); rdx(6, 8'h00, "R1 weekday");
    rdx(20, 8'h00, "R2 unused address");
    // R3 stopped clock ignores ticks
    tk(3);
    wrr(13, 8'h40);
    rdx(0, 8'h00, "R3 frozen sec");
    rdx(14, 8'h80, "R3 no flags while stopped");
    wrr(13, 8'h01);
    rdx(13, 8'h01, "R3 ctrl run");
    // R4 counting
    tk(3);
    wrr(13, 8'h41);
    rdx(0, 8'h03, "R4 sec count");
    rdx(13, 8'h01, "R7 snapshot bit reads 0");
    rdx(14, 8'h86, "R9 second flag");
    wrr(14, 8'h7C);
    rdx(14, 8'h82, "R9 R11 w1c keeps powerup");
    // R4 R5 R6 carries at midnight, non-leap February
    set_clock(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
    wrr(6, 8'h06);
    tk(2);
    wrr(13, 8'h41);
    rdx(0, 8'h00, "R4 sec wrap"); rdx(1, 8'h00, "R4 min wrap"); rdx(2, 8'h00, "R4 hour wrap");
    rdx(3, 8'h01, "R5 feb28 day"); rdx(4, 8'h03, "R5 feb28 month");
    rdx(6, 8'h00, "R6 weekday wrap");
    rdx(14, 8'hBE, "R9 all rollover flags");
    wrr(14, 8'h3C);
    // R5 leap February
    set_clock(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
    tk(1);
    wrr(13, 8'h41);
    rdx(3, 8'h29, "R5 leap day 29"); rdx(4, 8'h02, "R5 leap month");
    rdx(6, 8'h01, "R6 weekday advance");
    wrr(0, 8'h59); wrr(1, 8'h59); wrr(2, 8'h23);
    tk(1);
    wrr(13, 8'h41);
    rdx(3, 8'h01, "R5 leap wrap day"); rdx(4, 8'h03, "R5 leap wrap month");
    // R5 year and 30-day month
    set_clock(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
    tk(1);
    wrr(13, 8'h41);
    rdx(3, 8'h01, "R5 dec day"); rdx(4, 8'h01, "R5 dec month"); rdx(5, 8'h00, "R5 year wrap");
    set_clock(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h10);
    tk(1);
    wrr(13, 8'h41);
    rdx(3, 8'h01, "R5 april day"); rdx(4, 8'h05, "R5 april month");
    // R7 R8 shadow coherence and live write
    wrr(0, 8'h10);
    wrr(13, 8'h41);
    tk(2);
    rdx(0, 8'h10, "R7 shadow held");
    wrr(13, 8'h41);
    rdx(0, 8'h12, "R8 live write then count");
    // R12 periodic interrupt
    wrr(14, 8'h7C);
    wrr(15, 8'h04);
    chk_irq(0, "R12 no pending flag");
    tk(1);
    chk_irq(1, "R12 second irq");
    wrr(14, 8'h04);
    chk_irq(0, "R12 cleared flag drops irq");
    wrr(15, 8'h05);
    wrr(0, 8'h30);
    tk(1);
    chk_irq(0, "R12 minute rate ignores second flag");
    wrr(0, 8'h59);
    tk(1);
    chk_irq(1, "R12 minute irq");
    wrr(14, 8'h3C);
    wrr(15, 8'h00);
    // R10 alarm
    set_clock(8'h10, 8'h20, 8'h05, 8'h15, 8'h06, 8'h30);
    wrr(7, 8'h12); wrr(8, 8'h20); wrr(9, 8'h05); wrr(10, 8'h15); wrr(11, 8'h06); wrr(12, 8'h30);
    rdx(7, 8'h12, "R2 alarm seconds address");
    rdx(12, 8'h30, "R2 alarm year address");
    tk(1);
    rdx(14, 8'h86, "R10 no early alarm");
    tk(1);
    rdx(14, 8'hC6, "R10 alarm flag while disabled");
    chk_irq(0, "R12 alarm disabled");
    wrr(15, 8'h08);
    rdx(15, 8'h08, "R12 ien readback");
    chk_irq(1, "R12 alarm irq");
    wrr(14, 8'h00);
    chk_irq(1, "R10 write 0 keeps alarm");
    rdx(14, 8'hC6, "R10 sticky status");
    wrr(14, 8'h40);
    chk_irq(0, "R10 w1c alarm drops irq");
    rdx(14, 8'h86, "R10 alarm cleared");
    // R11 powerup clear
    wrr(14, 8'h80);
    rdx(14, 8'h06, "R11 powerup cleared");
    wrr(14, 8'h7C);
    rdx(14, 8'h02, "R9 flags cleared");
    // R3 stop
    wrr(13, 8'h00);
    tk(1);
    rdx(14, 8'h00, "R3 stopped status");
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule